// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the software-facing front end of an eight-line interrupt controller. It is reached through a byte-wide port with a one-bit address, and it sorts each byte into one of three kinds. The kinds are initialization words, operation commands, and read/poll control words. From these bytes it keeps the controller's configuration: the mask register, the vector base, the stored cascade word, the trigger and nesting flags, and the priority rotation offset. It also issues one-cycle strobes that tell the in-service register owner which line to retire. A separate strobe tells that owner to wipe its in-service and request state when initialization starts.

The block holds no priority logic of its own. A neighbouring resolver gives it two results. One is the highest line now in service, used by the non-specific end-of-interrupt commands. The other is the highest pending line, used by polling. Readback data is combinational. Register updates and clear strobes take effect on the clock edge that samples a write. The reset input is asserted asynchronously, and its release is synchronised inside the block over two clock edges.

Top module: `pic_cmd_seq`

## Requirements
- R1: A write to address 0 with bit 4 set starts initialization, and the level-mode bit 3 is ignored. On the next cycle the step is 1, and the mask, rotation offset, special mask and read select are all 0. The ICW4-derived flags are also 0. `init_clr` pulses for exactly one cycle, and the single-mode flag (bit 1) and fourth-word flag (bit 0) are captured.
- R2: An address-1 write in step 1 stores the vector base as the data AND 0xF8.
- R3: After the base word, the sequence is fixed by the two captured flags. Single mode without the fourth word returns to step 0. A cascaded setup goes to step 2, where an address-1 write is stored in `casc_word`. When the fourth word was requested, the next word goes to step 3; otherwise it goes to step 0.
- R4: An address-1 write in step 3 sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, then returns to step 0.
- R5: An address-1 write in step 0 loads the mask register with the full byte.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control word. When bit 1 is set, bit 0 picks the readback source (1 = in-service, 0 = request). When bit 6 is set, bit 5 becomes the special mask. A read at address 0 returns the chosen source, and a read at address 1 returns the mask.
- R7: Any other address-0 write is an operation command, with the code in bits 7:5. Code 0 clears the rotate-in-auto-EOI flag and code 4 sets it.
- R8: Code 1 pulses `isr_clr` one-hot at the resolver's highest in-service line on the cycle after the write. It pulses nothing if the resolver reports no line. Code 5 does the same and also sets the offset to that line + 1, modulo 8.
- R9: Code 3 pulses `isr_clr` for the line in bits 2:0. Code 7 also sets the offset to that line + 1, modulo 8. Code 2 changes nothing.
- R10: Code 6 sets the offset to (bits 2:0 + 1) modulo 8 and pulses no clear.
- R11: After a control word with bit 2 set, the next read returns 0x80 OR the pending line, or 0x00 when nothing is pending. During that read, `poll_ack` is high with `poll_ack_line` when a line is pending. The poll flag then clears, so later reads follow R6.
- R12: After reset the mask, vector base, cascade word, offset and all flags are 0, the step is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| irr_in | input | 8 | Request register from the request latch |
| isr_in | input | 8 | In-service register from its owner |
| hi_isr_valid | input | 1 | Resolver: some line is in service |
| hi_isr_line | input | 3 | Resolver: highest-priority in-service line |
| pend_valid | input | 1 | Resolver: an interrupt is pending |
| pend_line | input | 3 | Resolver: highest-priority pending line |
| imr | output | 8 | Mask register |
| vec_base | output | 8 | Vector base, low three bits zero |
| casc_word | output | 8 | Stored cascade word |
| single_mode | output | 1 | Single-controller mode flag |
| nested_mode | output | 1 | Special fully nested mode flag |
| auto_eoi | output | 1 | Automatic end-of-interrupt flag |
| rot_auto_eoi | output | 1 | Rotate on automatic EOI flag |
| special_mask | output | 1 | Special mask mode flag |
| prio_offset | output | 3 | Priority rotation offset |
| isr_clr | output | 8 | One-cycle in-service clear strobes |
| init_clr | output | 1 | One-cycle strobe to wipe ISR and IRR |
| poll_ack | output | 1 | Acknowledge of a polled line, during the read |
| poll_ack_line | output | 3 | Line acknowledged by poll |

## Verification
Two functions can meet in one cycle: a poll read, which clears the poll flag and acknowledges a line, and a new write. One case is a control word that sets poll again in the same cycle as the consuming read; the write must win, so the following read is again a poll read. The other case is an initialization word issued while clear strobes from an earlier command are still in flight. That case is judged by checking that `init_clr` and the cleared mask appear together, and that `isr_clr` stays one-hot or empty. The bench provokes both cases by driving read and write strobes in the same cycle, and it checks both the output that same cycle and the read that follows.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;

  localparam int unsigned NLINES = 8;
  localparam int unsigned LW     = $clog2(NLINES);

  // initialization step
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;

  // kind of an address-0 byte
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_INIT = 2'd1,
    WK_CTRL = 2'd2,
    WK_OPER = 2'd3
  } wkind_e;

  // operation command codes (bits 7:5)
  localparam logic [2:0] OP_ROT_OFF = 3'd0;
  localparam logic [2:0] OP_NS_EOI  = 3'd1;
  localparam logic [2:0] OP_NOP     = 3'd2;
  localparam logic [2:0] OP_SP_EOI  = 3'd3;
  localparam logic [2:0] OP_ROT_ON  = 3'd4;
  localparam logic [2:0] OP_NS_ROT  = 3'd5;
  localparam logic [2:0] OP_SET_PRI = 3'd6;
  localparam logic [2:0] OP_SP_ROT  = 3'd7;

endpackage

// File: rtl/seq_word_decode.sv
module seq_word_decode
  import pic_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output wkind_e        kind,
  output logic          data_wr,
  output logic [2:0]    op_code,
  output logic [LW-1:0] op_line
);

  localparam int unsigned INIT_BIT = 4;
  localparam int unsigned CTRL_BIT = 3;

  always_comb begin
    kind = WK_NONE;
    if (wr_en && !addr) begin
      if (wdata[INIT_BIT])      kind = WK_INIT;
      else if (wdata[CTRL_BIT]) kind = WK_CTRL;
      else                      kind = WK_OPER;
    end
  end

  assign data_wr = wr_en && addr;
  assign op_code = wdata[7:5];
  assign op_line = wdata[LW-1:0];

endmodule

// File: rtl/seq_init_fsm.sv
module seq_init_fsm
  import pic_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_go,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output init_st_e      state,
  output logic          single_mode,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_word,
  output logic          nested_mode,
  output logic          auto_eoi,
  output logic [DW-1:0] imr
);

  localparam logic [DW-1:0] BASE_MASK = ~DW'(NLINES - 1);

  init_st_e      st_q, st_d;
  logic          single_q, single_d;
  logic          need4_q, need4_d;
  logic [DW-1:0] base_q, base_d;
  logic [DW-1:0] casc_q, casc_d;
  logic          nest_q, nest_d;
  logic          aeoi_q, aeoi_d;
  logic [DW-1:0] imr_q, imr_d;

  always_comb begin
    st_d     = st_q;
    single_d = single_q;
    need4_d  = need4_q;
    base_d   = base_q;
    casc_d   = casc_q;
    nest_d   = nest_q;
    aeoi_d   = aeoi_q;
    imr_d    = imr_q;
    if (init_go) begin
      st_d     = ST_BASE;
      single_d = wdata[1];
      need4_d  = wdata[0];
      imr_d    = '0;
      nest_d   = 1'b0;
      aeoi_d   = 1'b0;
    end else if (data_wr) begin
      unique case (st_q)
        ST_IDLE: imr_d = wdata;
        ST_BASE: begin
          base_d = wdata & BASE_MASK;
          if (single_q) st_d = need4_q ? ST_MODE : ST_IDLE;
          else          st_d = ST_CASC;
        end
        ST_CASC: begin
          casc_d = wdata;
          st_d   = need4_q ? ST_MODE : ST_IDLE;
        end
        ST_MODE: begin
          nest_d = wdata[4];
          aeoi_d = wdata[1];
          st_d   = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
      base_q   <= '0;
      casc_q   <= '0;
      nest_q   <= 1'b0;
      aeoi_q   <= 1'b0;
      imr_q    <= '0;
    end else begin
      st_q     <= st_d;
      single_q <= single_d;
      need4_q  <= need4_d;
      base_q   <= base_d;
      casc_q   <= casc_d;
      nest_q   <= nest_d;
      aeoi_q   <= aeoi_d;
      imr_q    <= imr_d;
    end
  end

  assign state       = st_q;
  assign single_mode = single_q;
  assign vec_base    = base_q;
  assign casc_word   = casc_q;
  assign nested_mode = nest_q;
  assign auto_eoi    = aeoi_q;
  assign imr         = imr_q;

endmodule

// File: rtl/seq_op_unit.sv
module seq_op_unit
  import pic_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wkind_e            kind,
  input  logic [DW-1:0]     wdata,
  input  logic [2:0]        op_code,
  input  logic [LW-1:0]     op_line,
  input  logic              hi_valid,
  input  logic [LW-1:0]     hi_line,
  input  logic              rd_en,
  output logic [LW-1:0]     prio_offset,
  output logic              rot_auto_eoi,
  output logic              special_mask,
  output logic              rd_isr_sel,
  output logic              poll_pend,
  output logic [NLINES-1:0] isr_clr,
  output logic              init_clr
);

  logic [LW-1:0]     off_q, off_d;
  logic              rot_q, rot_d;
  logic              smask_q, smask_d;
  logic              rsel_q, rsel_d;
  logic              poll_q, poll_d;
  logic [NLINES-1:0] clr_q, clr_d;
  logic              iclr_q, iclr_d;

  always_comb begin
    off_d   = off_q;
    rot_d   = rot_q;
    smask_d = smask_q;
    rsel_d  = rsel_q;
    poll_d  = poll_q;
    clr_d   = '0;
    iclr_d  = 1'b0;
    if (rd_en && poll_q) poll_d = 1'b0;
    unique case (kind)
      WK_INIT: begin
        off_d   = '0;
        smask_d = 1'b0;
        rsel_d  = 1'b0;
        poll_d  = 1'b0;
        iclr_d  = 1'b1;
      end
      WK_CTRL: begin
        if (wdata[2]) poll_d  = 1'b1;
        if (wdata[1]) rsel_d  = wdata[0];
        if (wdata[6]) smask_d = wdata[5];
      end
      WK_OPER: begin
        unique case (op_code)
          OP_ROT_OFF, OP_ROT_ON: rot_d = op_code[2];
          OP_NS_EOI: if (hi_valid) clr_d[hi_line] = 1'b1;
          OP_NS_ROT: if (hi_valid) begin
            clr_d[hi_line] = 1'b1;
            off_d = hi_line + LW'(1);
          end
          OP_SP_EOI: clr_d[op_line] = 1'b1;
          OP_SET_PRI: off_d = op_line + LW'(1);
          OP_SP_ROT: begin
            clr_d[op_line] = 1'b1;
            off_d = op_line + LW'(1);
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      rot_q   <= 1'b0;
      smask_q <= 1'b0;
      rsel_q  <= 1'b0;
      poll_q  <= 1'b0;
      clr_q   <= '0;
      iclr_q  <= 1'b0;
    end else begin
      off_q   <= off_d;
      rot_q   <= rot_d;
      smask_q <= smask_d;
      rsel_q  <= rsel_d;
      poll_q  <= poll_d;
      clr_q   <= clr_d;
      iclr_q  <= iclr_d;
    end
  end

  assign prio_offset  = off_q;
  assign rot_auto_eoi = rot_q;
  assign special_mask = smask_q;
  assign rd_isr_sel   = rsel_q;
  assign poll_pend    = poll_q;
  assign isr_clr      = clr_q;
  assign init_clr     = iclr_q;

endmodule

// File: rtl/seq_read_mux.sv
module seq_read_mux
  import pic_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          rd_en,
  input  logic          addr,
  input  logic          poll_pend,
  input  logic          rd_isr_sel,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] imr,
  input  logic          pend_valid,
  input  logic [LW-1:0] pend_line,
  output logic [DW-1:0] rdata,
  output logic          poll_ack,
  output logic [LW-1:0] poll_ack_line
);

  logic [DW-1:0] poll_byte;

  always_comb begin
    poll_byte = '0;
    if (pend_valid) begin
      poll_byte[DW-1]   = 1'b1;
      poll_byte[LW-1:0] = pend_line;
    end
  end

  always_comb begin
    if (poll_pend)       rdata = poll_byte;
    else if (addr)       rdata = imr;
    else if (rd_isr_sel) rdata = isr_in;
    else                 rdata = irr_in;
  end

  assign poll_ack      = rd_en && poll_pend && pend_valid;
  assign poll_ack_line = pend_line;

endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] isr_in,
  input  logic          hi_isr_valid,
  input  logic [2:0]    hi_isr_line,
  input  logic          pend_valid,
  input  logic [2:0]    pend_line,
  output logic [DW-1:0] imr,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_word,
  output logic          single_mode,
  output logic          nested_mode,
  output logic          auto_eoi,
  output logic          rot_auto_eoi,
  output logic          special_mask,
  output logic [2:0]    prio_offset,
  output logic [7:0]    isr_clr,
  output logic          init_clr,
  output logic          poll_ack,
  output logic [2:0]    poll_ack_line
);

  logic [1:0] rst_pipe;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_q = rst_pipe[1];

  wkind_e        kind;
  logic          data_wr;
  logic [2:0]    op_code;
  logic [LW-1:0] op_line;
  init_st_e      state;
  logic          rd_isr_sel;
  logic          poll_pend;

  seq_word_decode #(.DW(DW)) u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .kind    (kind),
    .data_wr (data_wr),
    .op_code (op_code),
    .op_line (op_line)
  );

  seq_init_fsm #(.DW(DW)) u_init (
    .clk         (clk),
    .rst_n       (rst_n_q),
    .init_go     (kind == WK_INIT),
    .data_wr     (data_wr),
    .wdata       (wdata),
    .state       (state),
    .single_mode (single_mode),
    .vec_base    (vec_base),
    .casc_word   (casc_word),
    .nested_mode (nested_mode),
    .auto_eoi    (auto_eoi),
    .imr         (imr)
  );

  seq_op_unit #(.DW(DW)) u_op (
    .clk          (clk),
    .rst_n        (rst_n_q),
    .kind         (kind),
    .wdata        (wdata),
    .op_code      (op_code),
    .op_line      (op_line),
    .hi_valid     (hi_isr_valid),
    .hi_line      (hi_isr_line),
    .rd_en        (rd_en),
    .prio_offset  (prio_offset),
    .rot_auto_eoi (rot_auto_eoi),
    .special_mask (special_mask),
    .rd_isr_sel   (rd_isr_sel),
    .poll_pend    (poll_pend),
    .isr_clr      (isr_clr),
    .init_clr     (init_clr)
  );

  seq_read_mux #(.DW(DW)) u_rd (
    .rd_en         (rd_en),
    .addr          (addr),
    .poll_pend     (poll_pend),
    .rd_isr_sel    (rd_isr_sel),
    .isr_in        (isr_in),
    .irr_in        (irr_in),
    .imr           (imr),
    .pend_valid    (pend_valid),
    .pend_line     (pend_line),
    .rdata         (rdata),
    .poll_ack      (poll_ack),
    .poll_ack_line (poll_ack_line)
  );

endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] imr,
  input logic [2:0] prio_offset,
  input logic [7:0] isr_clr,
  input logic       init_clr,
  input logic       poll_pend,
  input logic [1:0] state
);

  // R1
  icw1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=>
      (imr == 8'h00 && prio_offset == 3'd0 && init_clr && state == 2'd1));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && state == 2'd0) |=> (imr == $past(wdata)));

  // R9
  spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[7:5] == 3'd3) |=>
      (isr_clr[$past(wdata[2:0])] && $countones(isr_clr) == 1));

  // R8
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr));

  // R10
  set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[7:5] == 3'd6) |=>
      (prio_offset == $past(wdata[2:0]) + 3'd1 && isr_clr == 8'h00));

  // R11
  poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_pend && !wr_en) |=> !poll_pend);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !(wr_en && !addr && wdata[4])) |=> (state == 2'd0));

endmodule

bind pic_cmd_seq pic_cmd_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_q),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .imr         (imr),
  .prio_offset (prio_offset),
  .isr_clr     (isr_clr),
  .init_clr    (init_clr),
  .poll_pend   (poll_pend),
  .state       (state)
);

// File: tb/tb_pic_cmd_seq.sv
`timescale 1ns/1ps
module tb_pic_cmd_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, addr;
  logic [7:0] wdata, rdata, irr_in, isr_in;
  logic       hi_isr_valid, pend_valid;
  logic [2:0] hi_isr_line, pend_line;
  logic [7:0] imr, vec_base, casc_word, isr_clr;
  logic       single_mode, nested_mode, auto_eoi, rot_auto_eoi, special_mask;
  logic [2:0] prio_offset, poll_ack_line;
  logic       init_clr, poll_ack;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
    .hi_isr_valid(hi_isr_valid), .hi_isr_line(hi_isr_line),
    .pend_valid(pend_valid), .pend_line(pend_line),
    .imr(imr), .vec_base(vec_base), .casc_word(casc_word),
    .single_mode(single_mode), .nested_mode(nested_mode), .auto_eoi(auto_eoi),
    .rot_auto_eoi(rot_auto_eoi), .special_mask(special_mask),
    .prio_offset(prio_offset), .isr_clr(isr_clr), .init_clr(init_clr),
    .poll_ack(poll_ack), .poll_ack_line(poll_ack_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d, output logic ack,
                    output logic [2:0] line);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    d = rdata; ack = poll_ack; line = poll_ack_line;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 imr", imr, 8'h00);
    chk("R12 base", vec_base, 8'h00);
    chk("R12 casc", casc_word, 8'h00);
    chk("R12 flags", {single_mode, nested_mode, auto_eoi, rot_auto_eoi, special_mask}, 5'b0);
    chk("R12 offset", prio_offset, 3'd0);
    chk("R12 strobes", {isr_clr, init_clr}, 9'h0);
  endtask

  task automatic t_init_single();
    logic [7:0] d; logic a; logic [2:0] l;
    wr(1'b0, 8'h1A);                       // R1 single, no ICW4, level bit ignored
    chk("R1 init_clr", init_clr, 1'b1);
    chk("R1 single", single_mode, 1'b1);
    @(negedge clk);
    chk("R1 init_clr one cycle", init_clr, 1'b0);
    wr(1'b1, 8'h47);
    chk("R2 base", vec_base, 8'h40);
    wr(1'b1, 8'h3C);                       // R3 back to idle: mask load
    chk("R3 single idle mask", imr, 8'h3C);
    rd(1'b1, d, a, l);
    chk("R6 read mask", d, 8'h3C);
  endtask

  task automatic t_init_full();
    wr(1'b0, 8'h11);                       // cascaded, ICW4 wanted
    chk("R1 cascaded", single_mode, 1'b0);
    chk("R1 imr cleared", imr, 8'h00);
    wr(1'b1, 8'h27);
    chk("R2 base masked", vec_base, 8'h20);
    wr(1'b1, 8'h04);
    chk("R3 cascade word", casc_word, 8'h04);
    chk("R3 imr untouched", imr, 8'h00);
    wr(1'b1, 8'h12);
    chk("R4 nested", nested_mode, 1'b1);
    chk("R4 auto_eoi", auto_eoi, 1'b1);
    wr(1'b1, 8'hA5);
    chk("R5 mask load", imr, 8'hA5);
    // cascaded without ICW4: cascade word then idle
    wr(1'b0, 8'h10);
    chk("R1 icw4 flags cleared", {nested_mode, auto_eoi}, 2'b00);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h02);
    chk("R3 cascade word 2", casc_word, 8'h02);
    wr(1'b1, 8'h5A);
    chk("R3 idle after cascade", imr, 8'h5A);
  endtask

  task automatic t_readback();
    logic [7:0] d; logic a; logic [2:0] l;
    irr_in = 8'h3C; isr_in = 8'h81;
    rd(1'b0, d, a, l);
    chk("R6 default irr", d, 8'h3C);
    wr(1'b0, 8'h0B);
    rd(1'b0, d, a, l);
    chk("R6 isr select", d, 8'h81);
    wr(1'b0, 8'h09);                       // bit1 clear: select unchanged
    rd(1'b0, d, a, l);
    chk("R6 select held", d, 8'h81);
    wr(1'b0, 8'h0A);
    rd(1'b0, d, a, l);
    chk("R6 irr select", d, 8'h3C);
    wr(1'b0, 8'h68);
    chk("R6 smask set", special_mask, 1'b1);
    wr(1'b0, 8'h28);
    chk("R6 smask held", special_mask, 1'b1);
    wr(1'b0, 8'h48);
    chk("R6 smask clear", special_mask, 1'b0);
  endtask

  task automatic t_ops();
    wr(1'b0, 8'h80);
    chk("R7 rot on", rot_auto_eoi, 1'b1);
    wr(1'b0, 8'h00);
    chk("R7 rot off", rot_auto_eoi, 1'b0);
    hi_isr_valid = 1'b1; hi_isr_line = 3'd6;
    wr(1'b0, 8'h20);
    chk("R8 ns eoi clr", isr_clr, 8'h40);
    @(negedge clk);
    chk("R8 strobe one cycle", isr_clr, 8'h00);
    hi_isr_valid = 1'b0;
    wr(1'b0, 8'h20);
    chk("R8 ns eoi none", isr_clr, 8'h00);
    hi_isr_valid = 1'b1; hi_isr_line = 3'd2;
    wr(1'b0, 8'hA0);
    chk("R8 ns rot clr", isr_clr, 8'h04);
    chk("R8 ns rot offset", prio_offset, 3'd3);
    hi_isr_line = 3'd7;
    wr(1'b0, 8'hA0);
    chk("R8 offset wrap", prio_offset, 3'd0);
    hi_isr_valid = 1'b0;
    wr(1'b0, 8'h63);
    chk("R9 specific clr", isr_clr, 8'h08);
    chk("R9 specific offset kept", prio_offset, 3'd0);
    wr(1'b0, 8'hE5);
    chk("R9 sp rot clr", isr_clr, 8'h20);
    chk("R9 sp rot offset", prio_offset, 3'd6);
    wr(1'b0, 8'h47);
    chk("R9 nop", {isr_clr, prio_offset}, {8'h00, 3'd6});
    wr(1'b0, 8'hC7);
    chk("R10 set prio wrap", prio_offset, 3'd0);
    chk("R10 no clr", isr_clr, 8'h00);
    wr(1'b0, 8'hC2);
    chk("R10 set prio", prio_offset, 3'd3);
  endtask

  task automatic t_poll();
    logic [7:0] d; logic a; logic [2:0] l;
    pend_valid = 1'b1; pend_line = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b1, d, a, l);
    chk("R11 poll byte", d, 8'h85);
    chk("R11 poll ack", {a, l}, {1'b1, 3'd5});
    rd(1'b1, d, a, l);
    chk("R11 flag cleared", d, 8'h5A);
    chk("R11 no ack", a, 1'b0);
    pend_valid = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0, d, a, l);
    chk("R11 none pending", {d, a}, {8'h00, 1'b0});
    // poll read meets a new poll request in the same cycle
    pend_valid = 1'b1; pend_line = 3'd1;
    wr(1'b0, 8'h0C);
    @(negedge clk);
    rd_en = 1'b1; addr = 1'b0; wr_en = 1'b1; wdata = 8'h0C;
    #1;
    chk("R11 concurrent read", rdata, 8'h81);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    rd(1'b1, d, a, l);
    chk("R11 poll rearmed", d, 8'h81);
    // init while clear strobe in flight
    @(negedge clk);
    wr_en = 1'b1; addr = 1'b0; wdata = 8'h63;
    @(negedge clk);
    wdata = 8'h13;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1 init after eoi", {init_clr, imr, isr_clr}, {1'b1, 8'h00, 8'h00});
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    irr_in = 8'h00; isr_in = 8'h00; hi_isr_valid = 1'b0; hi_isr_line = 3'd0;
    pend_valid = 1'b0; pend_line = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_init_single();
    t_init_full();
    t_readback();
    t_ops();
    t_poll();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule